// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt signal for a processor and, when the processor acknowledges, returns an 8-bit vector that identifies the winning line. Software reaches it through two byte-wide ports selected by one address bit. Port 0 is the control port and port 1 is the data port. Setup is a short sequence of initialization words. A control-port byte with bit 4 set opens the sequence. The data-port bytes that follow are consumed in order: the vector base, an optional cascade map, and an optional mode word. After that the controller runs, and data-port writes go to the interrupt mask.

In the running state, a rising edge on a request line latches a pending request. Fixed priority then picks the lowest-numbered unmasked pending line, as long as it outranks everything already in service. An acknowledge moves that line into service and emits its vector. A non-specific end-of-interrupt command (control byte 0x20) retires the highest-priority line in service. The vector leaves as a one-cycle valid pulse with no ready. There is no back-pressure, so the consumer must capture `vec_data` in the cycle `vec_valid` is high. The cascade map is held but does not affect routing. The mode word is accepted only to advance the sequence.

Top module: `pic_core`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are low, a data-port read returns 0x00, and data-port writes are ignored until a control byte with bit 4 set arrives.
- R2: A control write with bit 4 set restarts setup and clears the mask, all pending and all in-service bits. Bit 1 set (single) skips the cascade-map word. Bit 0 set makes a mode word follow. Any data write is taken as the next expected word. Setup ends after its last expected word.
- R3: The vector is {base[7:3], line[2:0]}, where base is the first data byte after the opening control byte, and its low three bits are ignored.
- R4: Once running, a data-port write loads the mask (bit i = 1 masks line i), and a data-port read (addr = 1, `rd_en` high) returns the mask in the same cycle.
- R5: Only a 0-to-1 transition of a line latches a request; a line held high does not latch again. A masked request stays pending and is raised once the line is unmasked.
- R6: Priority is fixed with line 0 highest. `int_out` is high only when an unmasked pending line has a smaller index than every in-service line.
- R7: An `inta` pulse while `int_out` is high sets that line's in-service bit, clears its pending bit, and raises `vec_valid` for exactly the next cycle with its vector. An `inta` while `int_out` is low does nothing.
- R8: A control write of exactly 0x20 while running clears the lowest-indexed in-service bit. Other control bytes with bit 4 clear have no effect.
- R9: During setup, `int_out` stays low and `inta` is ignored. Edges that arrive after the opening control byte stay latched and are served once setup ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = control port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (mask on data port once running, else 0) |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| vec_valid | output | 1 | One-cycle vector valid |
| vec_data | output | 8 | Vector of the acknowledged line |

## Verification
Wrong in-service state shows up on `int_out` within one cycle. A stale or lost in-service bit either blocks a higher-priority request or lets a lower one through, so the bench raises lines on both sides of the line in service and checks `int_out` after each end-of-interrupt. A sequencer in the wrong step shows up as a mask readback that differs from the last write, or as a vector carrying the wrong base, at the first read or acknowledge after setup. Lost or duplicated pending bits show up as vectors missing from, or extra to, the scoreboard order.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } init_st_t;

  localparam int          OPEN_BIT   = 4;
  localparam int          SINGLE_BIT = 1;
  localparam int          MODE_BIT   = 0;
  localparam logic [7:0]  CMD_NS_EOI = 8'h20;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_IRQ  = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_wr,
  input  logic                    data_wr,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    init_done,
  output logic                    restart,
  output logic                    eoi_cmd,
  output logic [DATA_W-IDX_W-1:0] vec_base,
  output logic [N_IRQ-1:0]        imr,
  output logic [N_IRQ-1:0]        slave_map
);
  init_st_t st_q, st_d;
  logic     single_q;
  logic     need_mode_q;

  assign restart   = ctl_wr && wdata[OPEN_BIT];
  assign init_done = (st_q == ST_RUN);
  assign eoi_cmd   = ctl_wr && init_done && (wdata == DATA_W'(CMD_NS_EOI));

  always_comb begin
    st_d = st_q;
    if (restart) begin
      st_d = ST_BASE;
    end else if (data_wr) begin
      unique case (st_q)
        ST_BASE: begin
          if (!single_q)       st_d = ST_CASC;
          else if (need_mode_q) st_d = ST_MODE;
          else                 st_d = ST_RUN;
        end
        ST_CASC: st_d = need_mode_q ? ST_MODE : ST_RUN;
        ST_MODE: st_d = ST_RUN;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
      vec_base    <= '0;
      imr         <= '0;
      slave_map   <= '0;
    end else begin
      st_q <= st_d;
      if (restart) begin
        single_q    <= wdata[SINGLE_BIT];
        need_mode_q <= wdata[MODE_BIT];
        imr         <= '0;
      end else if (data_wr) begin
        unique case (st_q)
          ST_BASE: vec_base  <= wdata[DATA_W-1:IDX_W];
          ST_CASC: slave_map <= wdata[N_IRQ-1:0];
          ST_RUN:  imr       <= wdata[N_IRQ-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             clear_all,
  input  logic [N_IRQ-1:0] take,
  output logic [N_IRQ-1:0] irr
);
  logic [N_IRQ-1:0] prev_q;
  logic [N_IRQ-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= irq_in;
      if (clear_all) irr <= '0;
      else           irr <= (irr & ~take) | rise;
    end
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N_IRQ = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_IRQ-1:0] vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_service.sv
module pic_service #(
  parameter int N_IRQ = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irr,
  input  logic [N_IRQ-1:0] imr,
  input  logic             init_done,
  input  logic             clear_all,
  input  logic             ack,
  input  logic             eoi,
  output logic             int_req,
  output logic [N_IRQ-1:0] take,
  output logic [IDX_W-1:0] win_idx,
  output logic [N_IRQ-1:0] isr
);
  logic [N_IRQ-1:0] pend;
  logic             pend_any;
  logic             isr_any;
  logic [IDX_W-1:0] isr_idx;
  logic             ack_ok;
  logic [N_IRQ-1:0] eoi_clr;

  assign pend = irr & ~imr;

  pic_prio_enc #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pend_enc (
    .vec(pend), .any(pend_any), .idx(win_idx)
  );

  pic_prio_enc #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_isr_enc (
    .vec(isr), .any(isr_any), .idx(isr_idx)
  );

  assign int_req = init_done && pend_any && (!isr_any || (win_idx < isr_idx));
  assign ack_ok  = ack && int_req;
  assign take    = ack_ok ? (N_IRQ'(1) << win_idx) : '0;
  assign eoi_clr = (eoi && isr_any) ? (N_IRQ'(1) << isr_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         isr <= '0;
    else if (clear_all) isr <= '0;
    else                isr <= (isr & ~eoi_clr) | take;
  end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int DATA_W = 8,
  parameter int N_IRQ  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_IRQ-1:0]  irq_in,
  output logic              int_out,
  input  logic              inta,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_data
);
  localparam int IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int BASE_W = DATA_W - IDX_W;

  logic              ctl_wr;
  logic              data_wr;
  logic              init_done;
  logic              restart;
  logic              eoi_cmd;
  logic [BASE_W-1:0] vec_base;
  logic [N_IRQ-1:0]  imr;
  logic [N_IRQ-1:0]  slave_map;
  logic [N_IRQ-1:0]  irr;
  logic [N_IRQ-1:0]  isr;
  logic [N_IRQ-1:0]  take;
  logic [IDX_W-1:0]  win_idx;
  logic              int_req;

  assign ctl_wr  = wr_en && !addr;
  assign data_wr = wr_en && addr;

  pic_init_seq #(.DATA_W(DATA_W), .N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_wr(data_wr), .wdata(wdata),
    .init_done(init_done), .restart(restart), .eoi_cmd(eoi_cmd),
    .vec_base(vec_base), .imr(imr), .slave_map(slave_map)
  );

  pic_req_latch #(.N_IRQ(N_IRQ)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clear_all(restart),
    .take(take), .irr(irr)
  );

  pic_service #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .irr(irr), .imr(imr), .init_done(init_done),
    .clear_all(restart), .ack(inta), .eoi(eoi_cmd), .int_req(int_req),
    .take(take), .win_idx(win_idx), .isr(isr)
  );

  assign int_out = int_req;
  assign rdata   = (rd_en && addr && init_done) ? DATA_W'(imr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= inta && int_req;
      if (inta && int_req) vec_data <= {vec_base, win_idx};
    end
  end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
  parameter int DATA_W = 8,
  parameter int N_IRQ  = 8,
  parameter int IDX_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    addr,
  input logic [DATA_W-1:0]       wdata,
  input logic                    inta,
  input logic                    int_out,
  input logic                    vec_valid,
  input logic [DATA_W-1:0]       vec_data,
  input logic [N_IRQ-1:0]        isr,
  input logic [N_IRQ-1:0]        irr,
  input logic [N_IRQ-1:0]        imr,
  input logic                    init_done,
  input logic [DATA_W-IDX_W-1:0] vec_base,
  input logic [N_IRQ-1:0]        slave_map
);
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(inta) && $past(int_out))); // R7
  AST_VEC_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> isr[vec_data[IDX_W-1:0]]); // R7
  AST_ONE_NEW_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr & ~$past(isr)) <= 1); // R7
  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_data[DATA_W-1:IDX_W] == vec_base)); // R3
  AST_NO_INT_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !int_out); // R9
  AST_INT_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0)); // R6
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata == DATA_W'(8'h20) && init_done && isr != '0 && !(inta && int_out))
      |=> ($countones(isr) == $countones($past(isr)) - 1)); // R8
  AST_CASC_MAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> $stable(slave_map)); // R2
endmodule

bind pic_core pic_core_chk #(.DATA_W(DATA_W), .N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .inta(inta), .int_out(int_out), .vec_valid(vec_valid), .vec_data(vec_data),
  .isr(isr), .irr(irr), .imr(imr), .init_done(init_done), .vec_base(vec_base),
  .slave_map(slave_map)
);

// File: tb/tb_pic_core.sv
module tb_pic_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       inta = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_data;

  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  pic_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
    .inta(inta), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every vector must match the next expected one
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R7 unexpected vector actual=0x%0h expected=none", vec_data);
      end else begin
        check("R3/R7", "vector", vec_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    addr = 1'b1; rd_en = 1'b1;
    #1;
    check(req, "data read", rdata, exp);
    rd_en = 1'b0;
  endtask

  task automatic line(input int i, input logic v);
    irq_in[i] = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] exp);
    exp_q.push_back(exp);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    check("R7", "vec_valid after ack", vec_valid, 1);
    @(negedge clk);
    check("R7", "vec_valid one cycle", vec_valid, 0);
  endtask

  task automatic ack_none(input string req);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    check(req, "ignored ack", vec_valid, 0);
  endtask

  task automatic int_chk(input string req, input logic exp);
    check(req, "int_out", int_out, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    int_chk("R1", 0);
    check("R1", "vec_valid", vec_valid, 0);
    rd_chk("R1", 8'h00);
    wr(1, 8'h55);
    rd_chk("R1", 8'h00);

    // full four-word setup: cascade selected, mode word requested
    wr(0, 8'h11);
    wr(1, 8'h20);
    rd_chk("R2", 8'h00);
    wr(1, 8'h04);
    rd_chk("R2", 8'h00);
    wr(1, 8'h01);
    rd_chk("R2", 8'h00);
    wr(1, 8'hFF);
    rd_chk("R4", 8'hFF);

    // masked request stays pending
    line(3, 1);
    int_chk("R5", 0);
    wr(1, 8'h00);
    int_chk("R5", 1);
    ack(8'h23);
    int_chk("R6", 0);
    ack_none("R7");

    // nesting against in-service line 3
    line(5, 1);
    int_chk("R6", 0);
    line(1, 1);
    int_chk("R6", 1);
    ack(8'h21);
    int_chk("R6", 0);
    wr(0, 8'h20);
    int_chk("R8", 0);
    wr(0, 8'h20);
    int_chk("R8", 1);
    ack(8'h25);
    wr(0, 8'h20);
    int_chk("R8", 0);
    irq_in = '0;
    @(negedge clk);

    // simultaneous edges resolve by fixed priority
    irq_in = 8'b0100_0100;
    @(negedge clk);
    int_chk("R6", 1);
    ack(8'h22);
    int_chk("R6", 0);
    wr(0, 8'h20);
    ack(8'h26);
    wr(0, 8'h20);
    repeat (3) @(negedge clk);
    int_chk("R5", 0);
    irq_in = '0;
    @(negedge clk);

    // control bytes other than 0x20 leave service untouched
    line(0, 1);
    ack(8'h20);
    line(4, 1);
    int_chk("R8", 0);
    wr(0, 8'h0A);
    int_chk("R8", 0);
    wr(0, 8'h60);
    int_chk("R8", 0);
    wr(0, 8'h20);
    int_chk("R8", 1);
    ack(8'h24);
    wr(0, 8'h20);
    irq_in = '0;
    @(negedge clk);

    // partial mask skips line 1
    wr(1, 8'h02);
    irq_in = 8'b0100_0010;
    @(negedge clk);
    int_chk("R4", 1);
    ack(8'h26);
    wr(0, 8'h20);
    int_chk("R4", 0);
    wr(1, 8'h00);
    int_chk("R5", 1);
    ack(8'h21);
    wr(0, 8'h20);
    irq_in = '0;
    @(negedge clk);

    // restart with single mode plus mode word, base low bits ignored
    wr(0, 8'h13);
    line(7, 1);
    int_chk("R9", 0);
    ack_none("R9");
    wr(1, 8'h4D);
    int_chk("R9", 0);
    wr(1, 8'h01);
    rd_chk("R2", 8'h00);
    int_chk("R9", 1);
    ack(8'h4F);
    wr(0, 8'h20);

    // single mode, no mode word: second data byte is the mask
    wr(0, 8'h12);
    wr(1, 8'h80);
    wr(1, 8'h0F);
    rd_chk("R2", 8'h0F);
    int_chk("R2", 0);
    wr(1, 8'h00);
    line(2, 1);
    ack(8'h82);
    wr(0, 8'h20);

    // restart in the middle of setup
    wr(0, 8'h11);
    wr(1, 8'h30);
    wr(0, 8'h13);
    wr(1, 8'h58);
    wr(1, 8'h01);
    rd_chk("R2", 8'h00);
    irq_in = '0;
    @(negedge clk);
    line(0, 1);
    ack(8'h58);
    wr(0, 8'h20);

    repeat (3) @(negedge clk);
    check("R7", "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule